// File: doc/BRIEF.md
# Cyclic Prefix Insertion Buffer

This block sits downstream of a transform engine and adds a cyclic prefix to every frame that passes through it. It stores one complete frame from a streaming input. It then plays the stored frame back on a streaming output twice over: first only the tail of the frame, as the prefix, and then the whole frame from its first sample. A receiver can then absorb channel spread in the prefix without losing frame content.

Both the frame length and the prefix length are set at runtime through a separate configuration stream. The frame length is given as the base-two logarithm of the sample count, so any power of two up to the built maximum can be chosen. The prefix length may be any count from zero up to one less than the frame length. A new setting takes effect only between frames. The buffer holds a single frame, so the input is closed while the stored frame is being played back. Readout follows the output's backpressure without dropping or repeating samples. The input's end-of-frame marker is compared against the configured length, and a sticky flag records any mismatch.

Top module: `cp_inserter`

## Requirements
- R1: After reset, `m_valid` and `frame_err` are 0 and both `s_ready` and `cfg_ready` are 1.
- R2: The configuration word holds log2 of the frame length in bits [7:0] and the prefix length in bits [15:8]. After reset these are 6 (64 samples) and 0. A word is taken only in a cycle with `cfg_valid` and `cfg_ready` both high. `cfg_ready` is high only when no sample of the next frame has yet been accepted and no readout is under way, and `s_ready` is low in any cycle where a configuration word is being taken.
- R3: Exactly 2^size samples are accepted per frame. After the last one, `s_ready` stays low until the final output sample of that frame has been transferred.
- R4: For a prefix length CP > 0, the output is the stored samples at indices N-CP through N-1 in order, then indices 0 through N-1, for N+CP transfers in all.
- R5: With a prefix length of 0, the output is exactly the N stored samples in order.
- R6: `m_last` is high only on the transfer carrying index N-1 of the full frame. It is never high at the end of the prefix.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` and `m_last` hold their values into the next cycle.
- R8: An input `s_last` on an accepted sample other than index N-1 sets `frame_err`.
- R9: An accepted sample at index N-1 without `s_last` sets `frame_err`. Once set, `frame_err` stays at 1 until reset.
- R10: The smallest and largest settings work: a 2-sample frame with a 1-sample prefix, and a 64-sample frame with a 63-sample prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_ready | output | 1 | Configuration word can be taken |
| cfg_data | input | 16 | Size field in [7:0], prefix length in [15:8] |
| s_valid | input | 1 | Input sample offered |
| s_ready | output | 1 | Input sample can be taken |
| s_data | input | DATA_W | Input sample |
| s_last | input | 1 | Input end-of-frame marker |
| m_valid | output | 1 | Output sample offered |
| m_ready | input | 1 | Downstream can take a sample |
| m_data | output | DATA_W | Output sample |
| m_last | output | 1 | Last sample of the full frame |
| frame_err | output | 1 | Sticky input frame-length mismatch |

## Verification
The hardest case to reach from the ports is a stalled output at the boundary between the end of the prefix and the restart at index 0, together with a prefix that wraps almost the whole buffer. The bench drives the output ready from a pseudo-random pattern during the 64-sample frame with a 63-sample prefix, so stalls land on that boundary and on the last sample. A scoreboard holds the expected stream, and every stalled cycle is checked for held data. Error detection is reached by sending frames whose end marker comes early or is missing, with a reset in between so that each case is seen on its own.

// File: rtl/cpi_pkg.sv
// Package: shared types and helpers for the cyclic prefix inserter.
// Assumes nothing beyond IEEE 1800-2017 packages.
package cpi_pkg;

    // Phase of the single-frame buffer.
    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_PREFIX = 2'd1,
        ST_BODY   = 2'd2
    } cpi_state_e;

    // Rounds a field width up to a whole number of bytes.
    function automatic int pad8(input int w);
        return ((w + 7) / 8) * 8;
    endfunction

endpackage

// File: rtl/cpi_cfg.sv
// Module: cpi_cfg
// Holds the active frame size and prefix length, and derives the last
// index, the prefix start index and the zero-prefix flag from them.
// Assumes the sequencer raises cfg_fire only between frames, and that
// the software gives a prefix length below the frame length.
module cpi_cfg
    import cpi_pkg::*;
#(
    parameter int MAX_LOG2 = 6,
    parameter int SZW      = 3,
    parameter int CFG_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_fire,
    input  logic [CFG_W-1:0]    cfg_word,
    output logic [MAX_LOG2-1:0] last_idx,
    output logic [MAX_LOG2-1:0] prefix_start,
    output logic                cp_zero
);
    localparam int AW     = MAX_LOG2;
    localparam int SZ_FLD = pad8(SZW);

    logic [SZW-1:0] size_q;
    logic [AW-1:0]  cp_q;
    logic [AW:0]    npts;
    logic           unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_word;

    // Latches a new size and prefix length when a word is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= SZW'(MAX_LOG2);
            cp_q   <= '0;
        end else if (cfg_fire) begin
            size_q <= cfg_word[SZW-1:0];
            cp_q   <= cfg_word[SZ_FLD +: AW];
        end
    end

    // Derives the frame boundaries from the latched fields.
    always_comb begin
        npts         = (AW+1)'(1) << size_q;
        last_idx     = AW'(npts - (AW+1)'(1));
        prefix_start = AW'(npts - {1'b0, cp_q});
        cp_zero      = (cp_q == '0);
    end

endmodule

// File: rtl/cpi_store.sv
// Module: cpi_store
// Frame storage: one write port and one asynchronous read port.
// Assumes the depth is small enough for a register array.
module cpi_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // Writes one accepted input sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Presents the addressed sample to the output.
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/cpi_seq.sv
// Module: cpi_seq
// Sequencer: fills the buffer, then reads the prefix and then the whole
// frame; it drives all handshakes and the sticky length error.
// Assumes last_idx and prefix_start stay constant outside ST_FILL.
module cpi_seq
    import cpi_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] last_idx,
    input  logic [AW-1:0] prefix_start,
    input  logic          cp_zero,
    input  logic          cfg_valid,
    output logic          cfg_ready,
    output logic          cfg_fire,
    input  logic          s_valid,
    input  logic          s_last,
    output logic          s_ready,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          m_valid,
    input  logic          m_ready,
    output logic          m_last,
    output logic          frame_err
);
    cpi_state_e    st;
    logic [AW-1:0] wr_cnt;
    logic [AW-1:0] rd_q;
    logic          err_q;
    logic          in_fire;
    logic          out_fire;

    // Decodes handshakes from the current phase.
    always_comb begin
        cfg_ready = (st == ST_FILL) && (wr_cnt == '0);
        cfg_fire  = cfg_ready && cfg_valid;
        s_ready   = (st == ST_FILL) && !cfg_fire;
        in_fire   = s_ready && s_valid;
        m_valid   = (st != ST_FILL);
        out_fire  = m_valid && m_ready;
        m_last    = (st == ST_BODY) && (rd_q == last_idx);
    end

    assign wr_en     = in_fire;
    assign wr_addr   = wr_cnt;
    assign rd_addr   = rd_q;
    assign frame_err = err_q;

    // Steps the phase, counters and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_FILL;
            wr_cnt <= '0;
            rd_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            case (st)
                ST_FILL: if (in_fire) begin
                    if (s_last != (wr_cnt == last_idx)) err_q <= 1'b1;
                    if (wr_cnt == last_idx) begin
                        wr_cnt <= '0;
                        if (cp_zero) begin
                            st   <= ST_BODY;
                            rd_q <= '0;
                        end else begin
                            st   <= ST_PREFIX;
                            rd_q <= prefix_start;
                        end
                    end else begin
                        wr_cnt <= wr_cnt + 1'b1;
                    end
                end
                ST_PREFIX: if (out_fire) begin
                    if (rd_q == last_idx) begin
                        st   <= ST_BODY;
                        rd_q <= '0;
                    end else begin
                        rd_q <= rd_q + 1'b1;
                    end
                end
                ST_BODY: if (out_fire) begin
                    if (rd_q == last_idx) st <= ST_FILL;
                    else rd_q <= rd_q + 1'b1;
                end
                default: st <= ST_FILL;
            endcase
        end
    end

    // Input is closed whenever a frame is being read out.
    assert_input_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    // A configuration word is never taken during readout.
    assert_cfg_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ready |-> !m_valid);

    // The frame marker only appears on an offered sample.
    assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        m_last |-> m_valid);

    // A stalled output keeps its read position.
    assert_stall_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> (m_valid && $stable(rd_addr) && $stable(m_last)));

    // The length error never clears by itself.
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> frame_err);

endmodule

// File: rtl/cp_inserter.sv
// Module: cp_inserter
// Top level of the cyclic prefix inserter: configuration latch, frame
// store and readout sequencer joined together.
// Assumes legal configuration words (size <= MAX_LOG2, prefix < frame).
module cp_inserter
    import cpi_pkg::*;
#(
    parameter  int DATA_W   = 16,
    parameter  int MAX_LOG2 = 6,
    localparam int SZW      = $clog2(MAX_LOG2 + 1),
    localparam int CFG_W    = pad8(SZW) + pad8(MAX_LOG2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    output logic              cfg_ready,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              s_valid,
    output logic              s_ready,
    input  logic [DATA_W-1:0] s_data,
    input  logic              s_last,
    output logic              m_valid,
    input  logic              m_ready,
    output logic [DATA_W-1:0] m_data,
    output logic              m_last,
    output logic              frame_err
);
    localparam int AW = MAX_LOG2;

    logic [AW-1:0] last_idx;
    logic [AW-1:0] prefix_start;
    logic          cp_zero;
    logic          cfg_fire;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    cpi_cfg #(.MAX_LOG2(MAX_LOG2), .SZW(SZW), .CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_fire(cfg_fire), .cfg_word(cfg_data),
        .last_idx(last_idx), .prefix_start(prefix_start), .cp_zero(cp_zero)
    );

    cpi_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(s_data),
        .rd_addr(rd_addr), .rd_data(m_data)
    );

    cpi_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst_n(rst_n), .last_idx(last_idx),
        .prefix_start(prefix_start), .cp_zero(cp_zero),
        .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_fire(cfg_fire),
        .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
        .m_valid(m_valid), .m_ready(m_ready), .m_last(m_last),
        .frame_err(frame_err)
    );

    // Output data holds steady while the downstream stalls.
    assert_stall_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_valid && !m_ready) |=> $stable(m_data));

endmodule

// File: tb/test_cp_inserter.sv
`timescale 1ns/1ps
module test_cp_inserter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic        cfg_ready;
    logic [15:0] cfg_data = '0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [15:0] s_data = '0;
    logic        s_last = 1'b0;
    logic        m_valid;
    logic        m_ready = 1'b1;
    logic [15:0] m_data;
    logic        m_last;
    logic        frame_err;

    int n_chk = 0;
    int n_bad = 0;
    int ready_mode = 0;
    bit finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [16:0] exp_q [$];

    always #2 clk = ~clk;

    cp_inserter i_cp_inserter (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
        .cfg_data(cfg_data), .s_valid(s_valid), .s_ready(s_ready),
        .s_data(s_data), .s_last(s_last), .m_valid(m_valid),
        .m_ready(m_ready), .m_data(m_data), .m_last(m_last),
        .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Monitor: sets the output ready, then compares transfers and stalls.
    initial begin
        logic       was_stalled = 1'b0;
        logic [16:0] held = '0;
        forever begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m_ready = (ready_mode == 0) ? 1'b1 : (ready_mode == 1) ? lfsr[0] : 1'b0;
            #1;
            if (was_stalled) begin
                check(m_valid && {m_last, m_data} == held, "R7 stall hold",
                      int'({m_last, m_data}), int'(held));
            end
            if (m_valid && m_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected output", int'(m_data), 0);
                end else begin
                    logic [16:0] e;
                    e = exp_q.pop_front();
                    check(m_data == e[15:0], "R4 data", int'(m_data), int'(e[15:0]));
                    check(m_last == e[16], "R6 last", int'(m_last), int'(e[16]));
                end
            end
            was_stalled = m_valid && !m_ready;
            held = {m_last, m_data};
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(4 * 150000);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_cfg(input int sz, input int cp);
        @(negedge clk);
        cfg_data = {8'(cp), 8'(sz)};
        cfg_valid = 1'b1;
        s_valid = 1'b1;
        #1;
        while (!cfg_ready) begin
            @(negedge clk);
            #1;
        end
        check(s_ready == 1'b0, "R2 sample blocked during config", int'(s_ready), 0);
        @(negedge clk);
        cfg_valid = 1'b0;
        s_valid = 1'b0;
    endtask

    // Driver: pushes the expected stream, then offers the samples.
    task automatic send_frame(input int id, input int sz, input int cp, input int last_at);
        int n;
        n = 1 << sz;
        for (int i = n - cp; i < n; i++) exp_q.push_back({1'b0, 8'(id), 8'(i)});
        for (int i = 0; i < n; i++) exp_q.push_back({(i == n - 1), 8'(id), 8'(i)});
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data = {8'(id), 8'(i)};
            s_last = (i == last_at);
            #1;
            while (!s_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last = 1'b0;
    endtask

    task automatic drain(input string req);
        int t = 0;
        while (exp_q.size() != 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        do_reset();
        #1;
        check(m_valid == 1'b0, "R1 m_valid", int'(m_valid), 0);
        check(s_ready == 1'b1, "R1 s_ready", int'(s_ready), 1);
        check(cfg_ready == 1'b1, "R1 cfg_ready", int'(cfg_ready), 1);
        check(frame_err == 1'b0, "R1 frame_err", int'(frame_err), 0);

        // R2 defaults: 64 samples with no prefix (also R5).
        send_frame(1, 6, 0, 63);
        drain("R2 default frame drained");

        // R4 and R6: 8-sample frame with a 3-sample prefix.
        send_cfg(3, 3);
        send_frame(2, 3, 3, 7);
        drain("R4 prefix frame drained");

        // R5: zero prefix under random backpressure.
        ready_mode = 1;
        send_cfg(3, 0);
        send_frame(3, 3, 0, 7);
        drain("R5 no prefix drained");

        // R10: smallest frame with a 1-sample prefix, then largest.
        send_cfg(1, 1);
        send_frame(4, 1, 1, 1);
        drain("R10 small frame drained");
        send_cfg(6, 63);
        send_frame(5, 6, 63, 63);
        drain("R10 large frame drained");

        // R3: input stays closed while the output is held off.
        ready_mode = 2;
        send_cfg(4, 5);
        send_frame(6, 4, 5, 15);
        repeat (10) @(negedge clk);
        #1;
        check(s_ready == 1'b0, "R3 input closed", int'(s_ready), 0);
        check(cfg_ready == 1'b0, "R3 config closed", int'(cfg_ready), 0);
        check(m_valid == 1'b1, "R3 output pending", int'(m_valid), 1);
        ready_mode = 1;
        drain("R3 frame drained");
        ready_mode = 0;
        check(frame_err == 1'b0, "R8 no error on good frames", int'(frame_err), 0);

        // R8: early end marker.
        send_cfg(3, 2);
        send_frame(7, 3, 2, 2);
        drain("R8 frame drained");
        check(frame_err == 1'b1, "R8 early last", int'(frame_err), 1);

        // R9: missing end marker, then stickiness.
        do_reset();
        #1;
        check(frame_err == 1'b0, "R9 cleared by reset", int'(frame_err), 0);
        send_cfg(2, 1);
        send_frame(8, 2, 1, -1);
        drain("R9 frame drained");
        check(frame_err == 1'b1, "R9 missing last", int'(frame_err), 1);
        send_frame(9, 2, 1, 3);
        drain("R9 good frame drained");
        check(frame_err == 1'b1, "R9 sticky", int'(frame_err), 1);

        finish_run();
    end
endmodule